// File: doc/BRIEF.md
# Boundary-Scan I/O Register Chain

This block places a scan register between the core and the pads of a bank of device pins. Each pin owns three cells: one watches the incoming pad value, one carries the value meant for the pad output, and one carries that output's enable. Every cell pairs a shift stage with an update stage. All shift stages are joined into a single serial path from the test data input to the test data output. An external test access controller drives the capture, shift and update strobes on the test clock and selects the pin behaviour through a two-bit mode.

In the functional mode the pads follow the core untouched, and the cells can still take a snapshot of the live signals or be preloaded. In the test modes the pads are driven from the update stages so that board wiring can be exercised. Pads can also be all released to high impedance, or held at the preloaded values. The number of pins is a parameter.

Top module: `bscan_io_chain`

## Requirements
- R1: While `rst_n` is low, every shift and update stage clears to 0. After reset, `scan_out` reads 0 and in mode EXTEST (01) `pad_out` and `pad_oe` are all 0.
- R2: The serial path is exactly 3*NPINS stages long. A word shifted in on `scan_in` appears unchanged and in the same bit order on `scan_out` during the next 3*NPINS shift cycles.
- R3: On a clock with `capture_en` high, each input cell loads `pad_in`, each output cell loads `core_out` and each control cell loads `core_oe`. In the shift cycles that follow, the bits leave in this order: pin 0 control, pin 0 output, pin 0 input, then pin 1 control, and so on. Serial bit k therefore belongs to pin k/3, with k%3 = 0 control, 1 output and 2 input.
- R4: An update stage changes only on a clock with `update_en` high, when it copies its shift stage. Shifting without an update leaves the pads unchanged.
- R5: In mode SAMPLE (00), `pad_out` = `core_out`, `pad_oe` = `core_oe` and `core_in` = `pad_in`, whatever the scan activity.
- R6: In mode EXTEST (01), `pad_out[i]` and `pad_oe[i]` come from the update stages of pin i's output and control cells, and `core_in[i]` comes from the update stage of its input cell.
- R7: In mode HIGHZ (10), every `pad_oe` bit is 0, `pad_out` follows `core_out`, and `core_in` comes from the input cells' update stages.
- R8: In mode CLAMP (11), `pad_out` and `pad_oe` come from the update stages as in EXTEST, and `core_in` comes from the input cells' update stages.
- R9: With none of `capture_en`, `shift_en` or `update_en` high, the shift stages hold their contents even while `pad_in` and the core signals change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all stages act on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Pin behaviour: 00 SAMPLE, 01 EXTEST, 10 HIGHZ, 11 CLAMP |
| capture_en | input | 1 | Load the shift stages from their parallel sources |
| shift_en | input | 1 | Move the serial path one stage toward `scan_out` |
| update_en | input | 1 | Copy the shift stages into the update stages |
| scan_in | input | 1 | Serial data entering the chain |
| scan_out | output | 1 | Serial data leaving the chain (pin 0 control cell) |
| core_out | input | NPINS | Output values from the core |
| core_oe | input | NPINS | Output enables from the core |
| core_in | output | NPINS | Input values delivered to the core |
| pad_in | input | NPINS | Values received at the pads |
| pad_out | output | NPINS | Values driven to the pads |
| pad_oe | output | NPINS | Output enables driven to the pads |

## Verification
The assertions take for granted that the controller raises at most one of the capture, shift and update strobes in any clock. They also assume that the mode does not change in the middle of a capture, shift and update sequence. The stimulus keeps to this by raising each strobe on its own for whole cycles and by changing the mode only between complete sequences. It changes inputs on the falling edge and reads the outputs there too, away from the rising edge on which the stages act.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
   typedef enum logic [1:0] {
      BS_SAMPLE = 2'b00,
      BS_EXTEST = 2'b01,
      BS_HIGHZ  = 2'b10,
      BS_CLAMP  = 2'b11
   } bs_mode_e;

   localparam int CELLS_PER_PIN = 3;
   // position of each cell kind inside a pin's group, counted from the TDO side
   localparam int SLOT_CTL = 0;
   localparam int SLOT_OUT = 1;
   localparam int SLOT_IN  = 2;
endpackage

// File: rtl/bscan_cell.sv
module bscan_cell #(
   parameter bit RESET_VAL = 1'b0
) (
   input  logic tck,
   input  logic rst_n,
   input  logic cap_en,
   input  logic sh_en,
   input  logic upd_en,
   input  logic par_in,
   input  logic ser_in,
   output logic ser_out,
   output logic upd_q
);
   logic stage_q;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)
         stage_q <= RESET_VAL;
      else if (cap_en)
         stage_q <= par_in;
      else if (sh_en)
         stage_q <= ser_in;
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)
         upd_q <= RESET_VAL;
      else if (upd_en)
         upd_q <= stage_q;
   end

   assign ser_out = stage_q;

   // R3: a capture loads the parallel source
   p_capture_load_r3: assert property (@(posedge tck) disable iff (!rst_n)
      cap_en |=> ser_out == $past(par_in));

   // R2: a shift moves the serial neighbour in
   p_shift_move_r2: assert property (@(posedge tck) disable iff (!rst_n)
      (sh_en && !cap_en) |=> ser_out == $past(ser_in));

   // R4: update stage steady without an update strobe
   p_upd_hold_r4: assert property (@(posedge tck) disable iff (!rst_n)
      !upd_en |=> $stable(upd_q));

   // R9: shift stage steady when idle
   p_idle_hold_r9: assert property (@(posedge tck) disable iff (!rst_n)
      (!cap_en && !sh_en) |=> $stable(ser_out));
endmodule

// File: rtl/bscan_pin.sv
module bscan_pin
   import bscan_pkg::*;
(
   input  logic     tck,
   input  logic     rst_n,
   input  bs_mode_e mode,
   input  logic     cap_en,
   input  logic     sh_en,
   input  logic     upd_en,
   input  logic     ser_in,
   output logic     ser_out,
   input  logic     core_out,
   input  logic     core_oe,
   output logic     core_in,
   input  logic     pad_in,
   output logic     pad_out,
   output logic     pad_oe
);
   // slot-indexed wiring: link[CELLS_PER_PIN] is the pin's serial entry
   logic [CELLS_PER_PIN:0]   link;
   logic [CELLS_PER_PIN-1:0] src;
   logic [CELLS_PER_PIN-1:0] held;

   assign link[CELLS_PER_PIN] = ser_in;
   assign ser_out             = link[0];

   assign src[SLOT_CTL] = core_oe;
   assign src[SLOT_OUT] = core_out;
   assign src[SLOT_IN]  = pad_in;

   for (genvar s = 0; s < CELLS_PER_PIN; s++) begin : g_slot
      bscan_cell u_cell (
         .tck     (tck),
         .rst_n   (rst_n),
         .cap_en  (cap_en),
         .sh_en   (sh_en),
         .upd_en  (upd_en),
         .par_in  (src[s]),
         .ser_in  (link[s+1]),
         .ser_out (link[s]),
         .upd_q   (held[s])
      );
   end

   always_comb begin
      pad_out = core_out;
      pad_oe  = core_oe;
      core_in = held[SLOT_IN];
      unique case (mode)
         BS_SAMPLE: core_in = pad_in;
         BS_EXTEST, BS_CLAMP: begin
            pad_out = held[SLOT_OUT];
            pad_oe  = held[SLOT_CTL];
         end
         BS_HIGHZ: pad_oe = 1'b0;
         default: pad_oe = 1'b0;
      endcase
   end

   // R7: released pads never enabled
   p_highz_release_r7: assert property (@(posedge tck) disable iff (!rst_n)
      (mode == BS_HIGHZ) |-> !pad_oe);

   // R5: functional mode is transparent between core and pad
   p_sample_pass_r5: assert property (@(posedge tck) disable iff (!rst_n)
      (mode == BS_SAMPLE) |-> (pad_out == core_out && pad_oe == core_oe && core_in == pad_in));
endmodule

// File: rtl/bscan_io_chain.sv
module bscan_io_chain
   import bscan_pkg::*;
#(
   parameter int NPINS = 4
) (
   input  logic             tck,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic             capture_en,
   input  logic             shift_en,
   input  logic             update_en,
   input  logic             scan_in,
   output logic             scan_out,
   input  logic [NPINS-1:0] core_out,
   input  logic [NPINS-1:0] core_oe,
   output logic [NPINS-1:0] core_in,
   input  logic [NPINS-1:0] pad_in,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pad_oe
);
   localparam int CHAIN_LEN = NPINS * CELLS_PER_PIN;

   if (NPINS < 1) begin : g_bad_npins
      $error("bscan_io_chain: NPINS must be at least 1");
   end
   if (CHAIN_LEN != NPINS * 3) begin : g_bad_len
      $error("bscan_io_chain: three cells per pin expected");
   end

   bs_mode_e mode_e;
   assign mode_e = bs_mode_e'(mode);

   // hop[NPINS] is the chain entry, hop[0] the exit; pin 0 nearest the exit
   logic [NPINS:0] hop;
   assign hop[NPINS] = scan_in;
   assign scan_out   = hop[0];

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      bscan_pin u_pin (
         .tck      (tck),
         .rst_n    (rst_n),
         .mode     (mode_e),
         .cap_en   (capture_en),
         .sh_en    (shift_en),
         .upd_en   (update_en),
         .ser_in   (hop[p+1]),
         .ser_out  (hop[p]),
         .core_out (core_out[p]),
         .core_oe  (core_oe[p]),
         .core_in  (core_in[p]),
         .pad_in   (pad_in[p]),
         .pad_out  (pad_out[p]),
         .pad_oe   (pad_oe[p])
      );
   end

   // input rule relied on by the cell checks (R3, R2, R4)
   p_strobe_excl_r3: assert property (@(posedge tck) disable iff (!rst_n)
      $onehot0({capture_en, shift_en, update_en}));

   // R6: in EXTEST the pads do not move unless an update happened
   p_extest_steady_r6: assert property (@(posedge tck) disable iff (!rst_n)
      (mode_e == BS_EXTEST && $stable(mode) && !$past(update_en)) |-> $stable(pad_out) && $stable(pad_oe));
endmodule

// File: tb/bscan_io_chain_bench.sv
module bscan_io_chain_bench;
   localparam int N = 4;
   localparam int L = 3 * N;
   localparam int NV = 6;

   logic tck = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] mode = 2'b00;
   logic capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0, scan_in = 1'b0;
   logic scan_out;
   logic [N-1:0] core_out = '0, core_oe = '0, pad_in = '0;
   logic [N-1:0] core_in, pad_out, pad_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 tck = ~tck;

   bscan_io_chain #(.NPINS(N)) u_bscan_io_chain (
      .tck(tck), .rst_n(rst_n), .mode(mode),
      .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
      .scan_in(scan_in), .scan_out(scan_out),
      .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   // {shift-in pattern[12], pad_in[4], core_out[4], core_oe[4]}
   localparam logic [23:0] VEC [NV] = '{
      24'hA5C_3_9_6,
      24'h000_F_F_F,
      24'hFFF_0_0_0,
      24'h5A3_A_5_C,
      24'h1E7_6_3_9,
      24'hC0F_9_C_3
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [L-1:0] stream_of(input logic [N-1:0] pi, input logic [N-1:0] co,
                                              input logic [N-1:0] oe);
      logic [L-1:0] s;
      for (int i = 0; i < N; i++) begin
         s[3*i]   = oe[i];
         s[3*i+1] = co[i];
         s[3*i+2] = pi[i];
      end
      return s;
   endfunction

   function automatic logic [N-1:0] pick(input logic [L-1:0] w, input int slot);
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) r[i] = w[3*i+slot];
      return r;
   endfunction

   task automatic do_capture();
      capture_en = 1'b1;
      @(negedge tck);
      capture_en = 1'b0;
   endtask

   task automatic do_update();
      update_en = 1'b1;
      @(negedge tck);
      update_en = 1'b0;
   endtask

   task automatic do_shift(input logic [L-1:0] din, output logic [L-1:0] dout);
      for (int k = 0; k < L; k++) begin
         shift_en = 1'b1;
         scan_in  = din[k];
         dout[k]  = scan_out;
         @(negedge tck);
      end
      shift_en = 1'b0;
      scan_in  = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge tck);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [L-1:0] got, pat, pat2;
      logic [N-1:0] pi, co, oe;

      // R1: reset state
      repeat (3) @(negedge tck);
      mode = 2'b01;
      #1;
      check("R1 pad_oe after reset", 32'(pad_oe), 32'h0);
      rst_n = 1'b1;
      @(negedge tck);
      check("R1 scan_out after reset", 32'(scan_out), 32'h0);
      check("R1 pad_out after reset", 32'(pad_out), 32'h0);
      check("R1 pad_oe after release", 32'(pad_oe), 32'h0);
      do_shift('0, got);
      check("R1 shift stages zero", 32'(got), 32'h0);

      // R2: chain length and order
      pat = 12'hB2D;
      do_shift(pat, got);
      do_shift('0, got);
      check("R2 word returns after 3N shifts", 32'(got), 32'(pat));

      // vector table: R3 R5 R6 R7 R8
      for (int v = 0; v < NV; v++) begin
         pat = VEC[v][23:12];
         pi  = VEC[v][11:8];
         co  = VEC[v][7:4];
         oe  = VEC[v][3:0];
         mode = 2'b00;
         pad_in = pi; core_out = co; core_oe = oe;
         @(negedge tck);
         check("R5 sample pad_out", 32'(pad_out), 32'(co));
         check("R5 sample pad_oe", 32'(pad_oe), 32'(oe));
         check("R5 sample core_in", 32'(core_in), 32'(pi));
         do_capture();
         do_shift(pat, got);
         check("R3 capture stream order", 32'(got), 32'(stream_of(pi, co, oe)));
         do_update();
         mode = 2'b01;
         @(negedge tck);
         check("R6 extest pad_out", 32'(pad_out), 32'(pick(pat, 1)));
         check("R6 extest pad_oe", 32'(pad_oe), 32'(pick(pat, 0)));
         check("R6 extest core_in", 32'(core_in), 32'(pick(pat, 2)));
         mode = 2'b11;
         @(negedge tck);
         check("R8 clamp pad_out", 32'(pad_out), 32'(pick(pat, 1)));
         check("R8 clamp pad_oe", 32'(pad_oe), 32'(pick(pat, 0)));
         check("R8 clamp core_in", 32'(core_in), 32'(pick(pat, 2)));
         mode = 2'b10;
         @(negedge tck);
         check("R7 highz pad_oe", 32'(pad_oe), 32'h0);
         check("R7 highz pad_out", 32'(pad_out), 32'(co));
         check("R7 highz core_in", 32'(core_in), 32'(pick(pat, 2)));
      end

      // R4: shifting without update leaves pads alone
      mode = 2'b01;
      pat = 12'h6C9;
      do_shift(pat, got);
      do_update();
      @(negedge tck);
      pat2 = ~pat;
      do_shift(pat2, got);
      check("R4 pad_out steady during shift", 32'(pad_out), 32'(pick(pat, 1)));
      check("R4 pad_oe steady during shift", 32'(pad_oe), 32'(pick(pat, 0)));
      do_update();
      check("R4 pad_out after update", 32'(pad_out), 32'(pick(pat2, 1)));
      check("R4 pad_oe after update", 32'(pad_oe), 32'(pick(pat2, 0)));

      // R9: idle cycles do not disturb captured data
      mode = 2'b00;
      pad_in = 4'h3; core_out = 4'hA; core_oe = 4'h6;
      @(negedge tck);
      do_capture();
      for (int i = 0; i < 5; i++) begin
         pad_in = ~pad_in; core_out = core_out + 4'd1; core_oe = ~core_oe;
         @(negedge tck);
      end
      do_shift('0, got);
      check("R9 idle hold", 32'(got), 32'(stream_of(4'h3, 4'hA, 4'h6)));

      // R5: sample path stays transparent while shifting
      core_out = 4'h9; core_oe = 4'h5; pad_in = 4'hE;
      shift_en = 1'b1;
      @(negedge tck);
      check("R5 transparent while shifting", 32'({pad_out, pad_oe, core_in}),
            32'({4'h9, 4'h5, 4'hE}));
      shift_en = 1'b0;
      @(negedge tck);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule